// File: doc/BRIEF.md
# Address Watchpoint Hit Recorder

This block watches a stream of bus transactions for one programmed address. Software loads a 32-bit watch address and sets an enable bit through a small register port. Each valid transaction is compared with the watch address. The first transaction whose address matches exactly is recorded: the full address goes into one status register, and the command direction and initiator number go into a second. A single-cycle pulse marks the recording.

Once a hit is recorded, the block is disarmed. Later matching transactions leave both status registers untouched until software writes to either status register. That write clears both registers and re-arms the block. A debugger or interrupt controller can therefore read the cause of the first access to a watched location, even if the location was accessed many times afterwards.

Initiator numbers follow the chip-wide map:
- 0 and 1: the processor in its non-secure and secure states.
- 6: the core interconnect.
- 8 to 10: the serial/security path.
- 12 to 14: DMA.

The block passes these numbers through unchanged.

Top module: `addr_watch_rec`

## Requirements
- R1: After reset, every register reads zero and `hit_pulse` is low.
- R2: The watch address at offset 0x08 is read/write over all 32 bits. Enable is bit 0 at offset 0x0C; bits [31:1] of 0x0C read zero.
- R3: A match needs the enable bit set, `txn_valid` high, and equality on all 32 address bits. On the clock edge of the matching transaction, offset 0x2C takes the transaction address.
- R4: Offset 0x30 holds the recorded direction in bit 4 (0 = read, 1 = write) and the initiator number in bits [3:0]. Bits [31:5] read zero.
- R5: After a recorded hit, later matches change neither status register and raise no pulse until a clear.
- R6: A write of any data to offset 0x2C or 0x30 clears both status registers in the same edge and re-arms the block. The next matching transaction is then recorded.
- R7: `hit_pulse` is high for exactly the one cycle after the edge that records a hit. It is never high in two consecutive cycles.
- R8: If a clear write and a matching transaction occur in the same cycle, the clear wins. The match is not recorded and no pulse is raised.
- R9: Reads of unmapped offsets return zero. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_valid | input | 1 | Transaction strobe, one per cycle |
| txn_addr | input | 32 | Transaction address |
| txn_wr | input | 1 | 1 = write, 0 = read |
| txn_init | input | 4 | Initiator number |
| reg_we | input | 1 | Register write strobe |
| reg_off | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_off` (combinational) |
| hit_pulse | output | 1 | One-cycle pulse on a recorded hit |

## Verification
The bench targets five corner cases:
- **Repeated matches after a hit.** A recorder that is not sticky would overwrite the stored address and initiator with later data.
- **An address that differs only in bit 0.** A comparator that drops low bits would record this access by mistake.
- **A clear write in the same cycle as a match.** This exposes the wrong priority: the design would keep a stale record or pulse anyway.
- **Clearing through each of the two status offsets.** A design that clears only the register written would leave half of the record in place.
- **A transaction held valid for two cycles.** A recorder that does not disarm itself would pulse twice.

// File: rtl/aw_pkg.sv
package aw_pkg;
    localparam int ADDR_W  = 32;
    localparam int ID_W    = 4;
    localparam int OFF_W   = 8;
    localparam int DATA_W  = 32;
    localparam int INFO_W  = ID_W + 1;

    localparam logic [OFF_W-1:0] OFF_WATCH = 8'h08;
    localparam logic [OFF_W-1:0] OFF_CTRL  = 8'h0C;
    localparam logic [OFF_W-1:0] OFF_HADDR = 8'h2C;
    localparam logic [OFF_W-1:0] OFF_HINFO = 8'h30;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_WATCH,
        SEL_CTRL,
        SEL_HADDR,
        SEL_HINFO
    } reg_sel_e;

    typedef struct packed {
        logic            is_wr;
        logic [ID_W-1:0] init;
    } hit_info_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        hit_info_t         info;
    } hit_rec_t;

    function automatic reg_sel_e decode_off(input logic [OFF_W-1:0] off);
        reg_sel_e s;
        case (off)
            OFF_WATCH: s = SEL_WATCH;
            OFF_CTRL:  s = SEL_CTRL;
            OFF_HADDR: s = SEL_HADDR;
            OFF_HINFO: s = SEL_HINFO;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pack_info(input hit_info_t i);
        logic [DATA_W-1:0] w;
        w = '0;
        w[INFO_W-1:0] = i;
        return w;
    endfunction
endpackage

// File: rtl/aw_regfile.sv
module aw_regfile
    import aw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] watch_addr,
    output logic              watch_en,
    output logic              clr_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            watch_addr <= '0;
            watch_en   <= 1'b0;
        end else if (reg_we) begin
            if (sel == SEL_WATCH) watch_addr <= wdata[ADDR_W-1:0];
            if (sel == SEL_CTRL)  watch_en   <= wdata[0];
        end
    end

    assign clr_req = reg_we && (sel == SEL_HADDR || sel == SEL_HINFO);
endmodule

// File: rtl/aw_match.sv
module aw_match
    import aw_pkg::*;
(
    input  logic              txn_valid,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic [ADDR_W-1:0] watch_addr,
    input  logic              watch_en,
    input  logic              armed,
    output logic              take
);
    logic eq;
    assign eq   = (txn_addr == watch_addr);
    assign take = txn_valid && watch_en && armed && eq;
endmodule

// File: rtl/aw_capture.sv
module aw_capture
    import aw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     take,
    input  logic     clr,
    input  hit_rec_t in_rec,
    output hit_rec_t rec,
    output logic     held,
    output logic     pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rec   <= '0;
            held  <= 1'b0;
            pulse <= 1'b0;
        end else if (clr) begin
            rec   <= '0;
            held  <= 1'b0;
            pulse <= 1'b0;
        end else if (take) begin
            rec   <= in_rec;
            held  <= 1'b1;
            pulse <= 1'b1;
        end else begin
            pulse <= 1'b0;
        end
    end
endmodule

// File: rtl/addr_watch_rec.sv
module addr_watch_rec
    import aw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_valid,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              txn_wr,
    input  logic [ID_W-1:0]   txn_init,
    input  logic              reg_we,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              hit_pulse
);
    reg_sel_e          sel;
    logic [ADDR_W-1:0] watch_addr;
    logic              watch_en;
    logic              clr_req;
    logic              take;
    logic              held;
    hit_rec_t          in_rec;
    hit_rec_t          rec;
    logic [ADDR_W-1:0] rec_addr;
    logic [INFO_W-1:0] rec_info;

    assign sel = decode_off(reg_off);

    aw_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .sel        (sel),
        .wdata      (reg_wdata),
        .watch_addr (watch_addr),
        .watch_en   (watch_en),
        .clr_req    (clr_req)
    );

    aw_match u_match (
        .txn_valid  (txn_valid),
        .txn_addr   (txn_addr),
        .watch_addr (watch_addr),
        .watch_en   (watch_en),
        .armed      (!held),
        .take       (take)
    );

    always_comb begin
        in_rec.addr       = txn_addr;
        in_rec.info.is_wr = txn_wr;
        in_rec.info.init  = txn_init;
    end

    aw_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .clr    (clr_req),
        .in_rec (in_rec),
        .rec    (rec),
        .held   (held),
        .pulse  (hit_pulse)
    );

    assign rec_addr = rec.addr;
    assign rec_info = rec.info;

    always_comb begin
        case (sel)
            SEL_WATCH: reg_rdata = watch_addr;
            SEL_CTRL:  reg_rdata = {{(DATA_W-1){1'b0}}, watch_en};
            SEL_HADDR: reg_rdata = rec_addr;
            SEL_HINFO: reg_rdata = pack_info(rec.info);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/aw_chk.sv
module aw_chk
    import aw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              txn_valid,
    input logic [ADDR_W-1:0] txn_addr,
    input logic              reg_we,
    input logic [OFF_W-1:0]  reg_off,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              hit_pulse,
    input logic              held,
    input logic [ADDR_W-1:0] rec_addr,
    input logic [INFO_W-1:0] rec_info
);
    logic clr_w;
    assign clr_w = reg_we && (reg_off == OFF_HADDR || reg_off == OFF_HINFO);

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        hit_pulse |=> !hit_pulse);

    // R3
    addr_taken_chk: assert property (@(posedge clk) disable iff (rst)
        hit_pulse |-> (rec_addr == $past(txn_addr) && $past(txn_valid)));

    // R6
    clear_both_chk: assert property (@(posedge clk) disable iff (rst)
        clr_w |=> (rec_addr == '0 && rec_info == '0 && !hit_pulse));

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (held && !clr_w) |=> ($stable(rec_addr) && $stable(rec_info) && !hit_pulse));

    // R4
    info_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_off == OFF_HINFO) |-> (reg_rdata[DATA_W-1:INFO_W] == '0));
endmodule

bind addr_watch_rec aw_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .txn_valid (txn_valid),
    .txn_addr  (txn_addr),
    .reg_we    (reg_we),
    .reg_off   (reg_off),
    .reg_rdata (reg_rdata),
    .hit_pulse (hit_pulse),
    .held      (held),
    .rec_addr  (rec_addr),
    .rec_info  (rec_info)
);

// File: tb/tb_addr_watch_rec.sv
`timescale 1ns/1ps
module tb_addr_watch_rec;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        txn_valid = 1'b0;
    logic [31:0] txn_addr = '0;
    logic        txn_wr = 1'b0;
    logic [3:0]  txn_init = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_off = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hit_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit prev_pulse = 0;

    typedef struct { logic [31:0] addr; logic [31:0] info; } exp_t;
    exp_t q[$];
    exp_t last;

    always #2 clk = ~clk;

    addr_watch_rec dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops scoreboard on every pulse
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (hit_pulse) begin
                chk(q.size() != 0, "R7 unexpected pulse", 32'(hit_pulse), 32'd0);
                chk(!prev_pulse, "R7 pulse longer than one cycle", 32'(prev_pulse), 32'd0);
                if (q.size() != 0) last = q.pop_front();
            end
            prev_pulse = hit_pulse;
        end
    end

    task automatic wr(input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_off = off; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] off, output logic [31:0] d);
        @(negedge clk);
        reg_off = off;
        #1 d = reg_rdata;
    endtask

    task automatic txn(input logic [31:0] a, input bit w, input logic [3:0] id, input bit expect_hit);
        exp_t e;
        @(negedge clk);
        txn_valid = 1'b1; txn_addr = a; txn_wr = w; txn_init = id;
        if (expect_hit) begin
            e.addr = a; e.info = {27'd0, w, id};
            q.push_back(e);
        end
        @(negedge clk);
        txn_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_regs(input string req, input logic [31:0] ea, input logic [31:0] ei);
        logic [31:0] d;
        chk(q.size() == 0, {req, " pulse count"}, 32'(q.size()), 32'd0);
        rd(8'h2C, d); chk(d == ea, {req, " hit address"}, d, ea);
        rd(8'h30, d); chk(d == ei, {req, " hit info"}, d, ei);
    endtask

    initial begin
        logic [31:0] d;
        exp_t e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(8'h08, d); chk(d == 0, "R1 watch", d, 0);
        rd(8'h0C, d); chk(d == 0, "R1 ctrl", d, 0);
        chk_regs("R1", 0, 0);
        chk(hit_pulse == 0, "R1 pulse", 32'(hit_pulse), 0);

        // R2 programming
        wr(8'h08, 32'h1234_5678);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h08, d); chk(d == 32'h1234_5678, "R2 watch readback", d, 32'h1234_5678);
        rd(8'h0C, d); chk(d == 32'h1, "R2 ctrl readback", d, 1);

        // R3 near miss, then hit (R4 read encoding: bit4=0, id in [3:0])
        txn(32'h1234_5679, 1'b0, 4'd6, 1'b0);
        chk_regs("R3 near miss", 0, 0);
        txn(32'h1234_5678, 1'b0, 4'd6, 1'b1);
        chk_regs("R3 R4 read hit", 32'h1234_5678, 32'h0000_0006);
        chk(last.info == 32'h6, "R7 scoreboard item", last.info, 32'h6);

        // R5 later match ignored
        txn(32'h1234_5678, 1'b1, 4'd13, 1'b0);
        chk_regs("R5 sticky", 32'h1234_5678, 32'h0000_0006);

        // R6 clear via info offset; re-arm; write hit encodes bit4=1
        wr(8'h30, 32'hDEAD_BEEF);
        chk_regs("R6 clear via 0x30", 0, 0);
        txn(32'h1234_5678, 1'b1, 4'd13, 1'b1);
        chk_regs("R4 R6 write hit after clear", 32'h1234_5678, 32'h0000_001D);

        // R6 clear via address offset
        wr(8'h2C, 32'h0);
        chk_regs("R6 clear via 0x2C", 0, 0);

        // R3 enable off blocks match
        wr(8'h0C, 32'h0);
        txn(32'h1234_5678, 1'b1, 4'd1, 1'b0);
        chk_regs("R3 disabled", 0, 0);
        wr(8'h0C, 32'h1);

        // R8 clear and match same cycle
        @(negedge clk);
        txn_valid = 1'b1; txn_addr = 32'h1234_5678; txn_wr = 1'b0; txn_init = 4'd9;
        reg_we = 1'b1; reg_off = 8'h2C; reg_wdata = 32'h5;
        @(negedge clk);
        txn_valid = 1'b0; reg_we = 1'b0;
        @(negedge clk);
        chk_regs("R8 clear wins", 0, 0);

        // R7 valid held two cycles gives a single pulse
        @(negedge clk);
        txn_valid = 1'b1; txn_addr = 32'h1234_5678; txn_wr = 1'b0; txn_init = 4'd14;
        e.addr = 32'h1234_5678; e.info = 32'h0000_000E; q.push_back(e);
        @(negedge clk);
        @(negedge clk);
        txn_valid = 1'b0;
        @(negedge clk);
        chk_regs("R7 held valid", 32'h1234_5678, 32'h0000_000E);

        // R9 unmapped offset
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, d); chk(d == 0, "R9 unmapped read", d, 0);
        rd(8'h08, d); chk(d == 32'h1234_5678, "R9 watch untouched", d, 32'h1234_5678);
        chk_regs("R9 status untouched", 32'h1234_5678, 32'h0000_000E);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule